// File: doc/BRIEF.md
# Return Address Stack with Status Pointer

This block keeps return addresses for subroutine calls in dedicated registers, apart from data memory. A call pushes a 21-bit address and a return pops the most recent one. The stack has 31 usable levels. Its pointer starts at 0 and is raised before each store, so level 0 never holds data and a pointer of 0 means the stack is empty.

The pointer shares one 8-bit register with two sticky error flags. One flag reports that the stack is full or has overflowed. The other reports that a pop was attempted on an empty stack. Software reads this register and writes it through a simple register port. Writing a flag bit as 0 clears that flag. Writing it as 1 leaves the flag unchanged. The pointer bits can be written directly.

Top module: `rstk_top`

## Requirements
- R1: After synchronous reset the status register reads 0x00 and `pop_addr_o` is 0.
- R2: A push with the pointer below 31 increments the pointer (status bits 4:0) and stores the address at the new level. That address then appears on `pop_addr_o`.
- R3: `pop_addr_o` always presents the address at the current level, or 0 when the pointer is 0. A pop with the pointer above 0 decrements the pointer, so addresses come back in reverse order of pushing.
- R4: A push that brings the pointer to 31 sets the full flag (status bit 7).
- R5: A push with the pointer already at 31 keeps the pointer at 31, stores nothing (the top address is unchanged) and sets the full flag.
- R6: A pop with the pointer at 0 sets the underflow flag (status bit 6), keeps the pointer at 0, and presents 0 on `pop_addr_o`.
- R7: Both flags stay set through later pushes and pops. A register write clears a flag only when its bit is written as 0. Writing 1 to a flag bit leaves that flag unchanged.
- R8: A register write loads status bits 4:0 into the pointer. Status bit 5 always reads 0.
- R9: Push and pop in the same cycle: `pop_addr_o` presents the old top in that cycle. The new address then replaces the top and the pointer is unchanged. With the pointer at 0, the underflow flag is set and nothing is stored.
- R10: A register write in the same cycle as a push or pop takes priority for the pointer, and the push still stores at pointer+1. A flag set by that push or pop stays set even when the write clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_i | input | 1 | Push request (call) |
| push_addr_i | input | 21 | Address to push |
| pop_i | input | 1 | Pop request (return) |
| pop_addr_o | output | 21 | Current top-of-stack address, 0 when empty |
| reg_wr_i | input | 1 | Status register write strobe |
| reg_wdata_i | input | 8 | Status register write data |
| reg_rdata_o | output | 8 | Status register: full, underflow, 0, pointer |

## Verification
Two kinds of event can fall in the same cycle. The first is a push together with a pop. The bench drives both requests at once with the pointer at a middle level and at 0. It checks that the old top is returned, that the top is replaced and the pointer is held, and that at level 0 the underflow flag is set. The second is a register write in the same cycle as a push or pop that sets a flag. The bench drives a push from level 30 and a pop at level 0 together with a write that clears the flags and loads a new pointer. It expects the written pointer and the flag raised by hardware.

// File: rtl/rstk_pkg.sv
package rstk_pkg;
    localparam int ADDR_W = 21;
    localparam int PTR_W  = 5;
    localparam int REG_W  = 8;
    localparam int DEPTH  = (1 << PTR_W) - 1;
    localparam int PAD_W  = REG_W - 2 - PTR_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [PTR_W-1:0]  ptr_t;
    typedef logic [REG_W-1:0]  sreg_t;

    localparam ptr_t PTR_TOP  = ptr_t'(DEPTH);
    localparam ptr_t PTR_LAST = ptr_t'(DEPTH - 1);

    typedef struct packed {
        logic full;
        logic unf;
    } flags_t;

    typedef struct packed {
        logic  en;
        ptr_t  idx;
        addr_t data;
    } store_req_t;

    function automatic sreg_t pack_status(flags_t f, ptr_t p);
        return {f.full, f.unf, {PAD_W{1'b0}}, p};
    endfunction
endpackage

// File: rtl/rstk_ctrl.sv
module rstk_ctrl
    import rstk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       push,
    input  logic       pop,
    input  addr_t      push_addr,
    input  logic       wr,
    input  flags_t     wr_flags,
    input  ptr_t       wr_ptr,
    output ptr_t       sp,
    output flags_t     flags,
    output store_req_t req
);
    ptr_t   sp_n;
    flags_t flags_n;
    logic   only_push, only_pop, both, set_full, set_unf;

    always_comb begin
        only_push = push && !pop;
        only_pop  = pop && !push;
        both      = push && pop;
        set_full  = only_push && (sp >= PTR_LAST);
        set_unf   = pop && (sp == '0);

        sp_n     = sp;
        req.en   = 1'b0;
        req.idx  = sp;
        req.data = push_addr;

        if (only_push && sp != PTR_TOP) begin
            sp_n    = ptr_t'(sp + 1'b1);
            req.en  = 1'b1;
            req.idx = ptr_t'(sp + 1'b1);
        end else if (only_pop && sp != '0) begin
            sp_n = ptr_t'(sp - 1'b1);
        end else if (both && sp != '0) begin
            req.en = 1'b1;
        end

        if (wr) sp_n = wr_ptr;

        flags_n = flags;
        if (wr) begin
            flags_n.full = flags.full & wr_flags.full;
            flags_n.unf  = flags.unf & wr_flags.unf;
        end
        flags_n.full = flags_n.full | set_full;
        flags_n.unf  = flags_n.unf | set_unf;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sp    <= '0;
            flags <= '0;
        end else begin
            sp    <= sp_n;
            flags <= flags_n;
        end
    end
endmodule

// File: rtl/rstk_store.sv
module rstk_store
    import rstk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  store_req_t req,
    input  ptr_t       rd_idx,
    output addr_t      rd_data
);
    addr_t lvl [0:DEPTH];

    assign lvl[0] = '0;

    for (genvar i = 1; i <= DEPTH; i++) begin : g_lvl
        addr_t q;
        always_ff @(posedge clk) begin
            if (rst) q <= '0;
            else if (req.en && req.idx == ptr_t'(i)) q <= req.data;
        end
        assign lvl[i] = q;
    end

    assign rd_data = lvl[rd_idx];
endmodule

// File: rtl/rstk_top.sv
module rstk_top
    import rstk_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        push_i,
    input  logic [20:0] push_addr_i,
    input  logic        pop_i,
    output logic [20:0] pop_addr_o,
    input  logic        reg_wr_i,
    input  logic [7:0]  reg_wdata_i,
    output logic [7:0]  reg_rdata_o
);
    ptr_t       sp;
    flags_t     flags;
    store_req_t req;
    flags_t     wr_flags;

    assign wr_flags = '{full: reg_wdata_i[REG_W-1], unf: reg_wdata_i[REG_W-2]};

    rstk_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .push      (push_i),
        .pop       (pop_i),
        .push_addr (push_addr_i),
        .wr        (reg_wr_i),
        .wr_flags  (wr_flags),
        .wr_ptr    (reg_wdata_i[PTR_W-1:0]),
        .sp        (sp),
        .flags     (flags),
        .req       (req)
    );

    rstk_store u_store (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .rd_idx  (sp),
        .rd_data (pop_addr_o)
    );

    assign reg_rdata_o = pack_status(flags, sp);
endmodule

// File: rtl/rstk_chk.sv
module rstk_chk
    import rstk_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        push_i,
    input logic [20:0] push_addr_i,
    input logic        pop_i,
    input logic [20:0] pop_addr_o,
    input logic        reg_wr_i,
    input logic [7:0]  reg_wdata_i,
    input logic [7:0]  reg_rdata_o
);
    ptr_t sp;
    assign sp = reg_rdata_o[PTR_W-1:0];

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (reg_rdata_o == '0 && pop_addr_o == '0));

    p_push_inc_r2: assert property (@(posedge clk) disable iff (rst)
        (push_i && !pop_i && !reg_wr_i && sp != PTR_TOP)
        |=> (sp == ptr_t'($past(sp) + 1'b1) && pop_addr_o == $past(push_addr_i)));

    p_full_set_r4: assert property (@(posedge clk) disable iff (rst)
        (push_i && !pop_i && sp >= PTR_LAST) |=> reg_rdata_o[7]);

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        (push_i && !pop_i && !reg_wr_i && sp == PTR_TOP)
        |=> (sp == PTR_TOP && $stable(pop_addr_o)));

    p_underflow_r6: assert property (@(posedge clk) disable iff (rst)
        (pop_i && !reg_wr_i && sp == '0) |=> (reg_rdata_o[6] && sp == '0 && pop_addr_o == '0));

    p_sticky_full_r7: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata_o[7] && !(reg_wr_i && !reg_wdata_i[7])) |=> reg_rdata_o[7]);

    p_sticky_unf_r7: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata_o[6] && !(reg_wr_i && !reg_wdata_i[6])) |=> reg_rdata_o[6]);

    p_bit5_zero_r8: assert property (@(posedge clk) disable iff (rst)
        reg_rdata_o[5] == 1'b0);

    p_swap_r9: assert property (@(posedge clk) disable iff (rst)
        (push_i && pop_i && !reg_wr_i && sp != '0)
        |=> (sp == $past(sp) && pop_addr_o == $past(push_addr_i)));

    p_wr_ptr_r10: assert property (@(posedge clk) disable iff (rst)
        reg_wr_i |=> sp == $past(reg_wdata_i[PTR_W-1:0]));
endmodule

bind rstk_top rstk_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .push_i      (push_i),
    .push_addr_i (push_addr_i),
    .pop_i       (pop_i),
    .pop_addr_o  (pop_addr_o),
    .reg_wr_i    (reg_wr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o)
);

// File: tb/rstk_top_tb.sv
module rstk_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        push_i = 1'b0;
    logic [20:0] push_addr_i = '0;
    logic        pop_i = 1'b0;
    logic [20:0] pop_addr_o;
    logic        reg_wr_i = 1'b0;
    logic [7:0]  reg_wdata_i = '0;
    logic [7:0]  reg_rdata_o;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        logic [7:0]  reg_v;
        logic [20:0] top_v;
        string       tag;
    } exp_t;
    exp_t sbq [$];

    logic [20:0] m_mem [0:31];
    logic [4:0]  m_sp = '0;
    logic        m_full = 1'b0;
    logic        m_unf = 1'b0;

    rstk_top u_dut (
        .clk(clk), .rst(rst), .push_i(push_i), .push_addr_i(push_addr_i),
        .pop_i(pop_i), .pop_addr_o(pop_addr_o), .reg_wr_i(reg_wr_i),
        .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o)
    );

    always #5 clk = ~clk;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [20:0] m_top();
        return (m_sp == 0) ? 21'd0 : m_mem[m_sp];
    endfunction

    task automatic op(bit p, logic [20:0] a, bit q, bit w, logic [7:0] wd, string tag);
        logic [4:0] nsp;
        bit         sf, su;
        @(negedge clk);
        push_i = p; push_addr_i = a; pop_i = q; reg_wr_i = w; reg_wdata_i = wd;
        #1;
        if (q) check({tag, " pop value"}, 32'(pop_addr_o), 32'(m_top()));
        nsp = m_sp;
        sf  = p && !q && (m_sp >= 5'd30);
        su  = q && (m_sp == 0);
        if (p && !q && m_sp != 5'd31) begin
            nsp = m_sp + 5'd1;
            m_mem[nsp] = a;
        end else if (q && !p && m_sp != 0) begin
            nsp = m_sp - 5'd1;
        end else if (p && q && m_sp != 0) begin
            m_mem[m_sp] = a;
        end
        if (w) begin
            nsp = wd[4:0];
            m_full = m_full & wd[7];
            m_unf  = m_unf & wd[6];
        end
        m_full = m_full | sf;
        m_unf  = m_unf | su;
        m_sp   = nsp;
        sbq.push_back('{reg_v: {m_full, m_unf, 1'b0, m_sp}, top_v: m_top(), tag: tag});
        @(posedge clk);
        #1;
        push_i = 0; pop_i = 0; reg_wr_i = 0;
    endtask

    // Monitor: compares state after each operation's clock edge
    initial begin
        forever begin
            @(posedge clk);
            #3;
            if (sbq.size() > 0) begin
                exp_t it;
                it = sbq.pop_front();
                check({it.tag, " status"}, 32'(reg_rdata_o), 32'(it.reg_v));
                check({it.tag, " top"}, 32'(pop_addr_o), 32'(it.top_v));
            end
        end
    end

    initial begin
        #2000000;
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) m_mem[i] = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 0;
        @(posedge clk);
        #3;
        check("R1 reset status", 32'(reg_rdata_o), 32'h00);
        check("R1 reset top", 32'(pop_addr_o), 32'h0);

        // R2 pushes, R3 pops
        op(1, 21'h0_1234, 0, 0, 8'h00, "R2");
        op(1, 21'h1_5678, 0, 0, 8'h00, "R2");
        op(1, 21'h1F_FFFF, 0, 0, 8'h00, "R2");
        op(0, 21'h0, 1, 0, 8'h00, "R3");
        op(0, 21'h0, 1, 0, 8'h00, "R3");
        // R9 push+pop at level 1 and at level 0
        op(1, 21'h0_0AAA, 1, 0, 8'h00, "R9");
        op(0, 21'h0, 1, 0, 8'h00, "R3");
        op(1, 21'h0_0BBB, 1, 0, 8'h00, "R9 empty");
        op(0, 21'h0, 1, 0, 8'h00, "R6");
        // fill to 31: last push is R4
        for (int i = 1; i <= 31; i++)
            op(1, 21'h10000 + 21'(i), 0, 0, 8'h00, (i == 31) ? "R4" : "R2 fill");
        op(1, 21'h0_0CCC, 0, 0, 8'h00, "R5");
        op(0, 21'h0, 1, 0, 8'h00, "R5 pop");
        op(1, 21'h0_0DDD, 0, 0, 8'h00, "R2 refill");
        op(0, 21'h0, 0, 1, 8'hFF, "R7 write ones");
        op(0, 21'h0, 1, 0, 8'h00, "R7 sticky");
        op(0, 21'h0, 0, 1, 8'h25, "R8 write");
        op(0, 21'h0, 0, 1, 8'h80, "R8 zero");
        // R10 write with push/pop
        op(0, 21'h0, 0, 1, 8'h05, "R8 ptr");
        op(1, 21'h0_0EEE, 0, 1, 8'h02, "R10 push+write");
        op(0, 21'h0, 0, 1, 8'h1E, "R8 ptr30");
        op(1, 21'h0_0FFF, 0, 1, 8'h0A, "R10 full kept");
        op(0, 21'h0, 0, 1, 8'h00, "R7 clear");
        op(0, 21'h0, 1, 1, 8'h03, "R10 unf kept");
        op(0, 21'h0, 1, 0, 8'h00, "R3 after write");

        repeat (3) @(posedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule